// File: doc/BRIEF.md
# Whole-8 KiB CHR Bank Composer

This block forms the pattern-memory page numbers for a multi-game cartridge mapper while it runs in its whole-8 KiB CHR mode. In that mode the fine-grained per-slot bank registers play no part. The 8 KiB bank is built only from an outer bank register and, on boards that carry one, a small discrete-style bank latch.

Two board variants carry the latch, and they combine it differently. The "swap" variant replaces the low bank bits of the outer register with the latch bits. The "merge" variant ORs the latch bits onto the outer register and clears nothing. A static board-variant input picks the behaviour.

The block outputs eight 1 KiB page numbers, one for each 1 KiB slot of the 8 KiB pattern space. It also translates a 13-bit pattern-space address into a physical CHR ROM byte address. Register writes arrive through a small write port. Every output follows combinationally from the registers, so a write is visible right after the clock edge that takes it.

Top module: `chr8k_composer`

## Requirements
- R1: A clock edge with `rst` high clears the control bits, the outer bank and the latch to zero. After reset the eight pages read 0 to 7 and `chr8k_active` is 0.
- R2: When `wr_en` is high, the next clock edge stores `wr_data` according to `wr_sel`. Select 0 writes the control bits, select 1 writes the outer bank (low OUTER_W bits) and select 2 writes the latch (low LATCH_W bits, upper data bits dropped). The outputs show the new value right after that edge.
- R3: `chr8k_active` equals control bit 6 of the last value written with select 0.
- R4: The latch mask is zero when control bit 5 is set, and it is also zero when `board_variant` is 0 (no latch) or 3 (reserved, no latch). In every other case the mask is 1 if control bit 4 is set and 3 if bit 4 is clear.
- R5: With `board_variant` = 1 (swap), bank = (outer AND NOT mask) OR (latch AND mask).
- R6: With `board_variant` = 2 (merge), bank = outer OR (latch AND mask).
- R7: Slot i (0 to 7) carries page (bank*8 + i) mod CHR_ROM_KB. Slot i sits at `slot_pages[i*PAGE_W +: PAGE_W]`.
- R8: `chr_addr` = page of slot `ppu_addr[12:10]` times 1024, plus `ppu_addr[9:0]`.
- R9: A write with select 3 changes no register.
- R10: A bank beyond the ROM size wraps. With 1024 KiB of ROM, bank 0x81 maps to pages 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up and soft reset) |
| board_variant | input | 2 | Static board select: 0 none, 1 swap latch, 2 merge latch, 3 reserved |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 outer bank, 2 latch, 3 unused |
| wr_data | input | DATA_W | Write data |
| ppu_addr | input | 13 | Pattern-space address to translate |
| chr8k_active | output | 1 | Whole-8 KiB CHR mode enabled |
| slot_pages | output | 8*PAGE_W | Eight 1 KiB page numbers, slot 0 in the low bits |
| chr_addr | output | PAGE_W+10 | Physical CHR ROM byte address |

## Verification
The hardest case to reach is the difference between the two latch variants. It only shows when an outer bank with a low bit already set meets a latch value whose masked bits differ from it. It only shows when control bit 5 is clear, and bit 4 decides whether one or two bits are involved. The vector table therefore pairs outer values such as 5, 6 and 9 with latch values that collide with them, under both mask widths and under each variant. Other vectors set bit 5 or select a latch-less board, to show that the latch then drops out. One vector uses an outer bank past the ROM end together with a latch bit, so that substitution and wrap-around happen in the same case.

// File: rtl/chr_comp_pkg.sv
package chr_comp_pkg;
  // Board variants (static strap)
  typedef enum logic [1:0] {
    BV_PLAIN = 2'd0,
    BV_SWAP  = 2'd1,
    BV_MERGE = 2'd2,
    BV_RSVD  = 2'd3
  } board_t;

  // Write-port register selects
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_OUTER = 2'd1,
    SEL_LATCH = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_t;

  // Control bits kept from the control register
  typedef struct packed {
    logic whole8k;    // bit 6
    logic latch_off;  // bit 5
    logic small_win;  // bit 4
  } ctrl_t;

  localparam int SLOTS      = 8;
  localparam int SLOT_SHIFT = 3;
  localparam int SLOT_KB_W  = 10;
endpackage

// File: rtl/chr_cfg_regs.sv
module chr_cfg_regs
  import chr_comp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 8,
  parameter int LATCH_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output ctrl_t              ctrl_q,
  output logic [OUTER_W-1:0] outer_q,
  output logic [LATCH_W-1:0] latch_q
);
  wsel_t sel;
  assign sel = wsel_t'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      outer_q <= '0;
      latch_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:  ctrl_q  <= '{whole8k: wr_data[6], latch_off: wr_data[5], small_win: wr_data[4]};
        SEL_OUTER: outer_q <= wr_data[OUTER_W-1:0];
        SEL_LATCH: latch_q <= wr_data[LATCH_W-1:0];
        default: ;
      endcase
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && outer_q == '0 && latch_q == '0));

  assert_outer_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=> outer_q == $past(wr_data[OUTER_W-1:0]));

  assert_sel3_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(ctrl_q) && $stable(outer_q) && $stable(latch_q)));
endmodule

// File: rtl/chr_bank_mix.sv
module chr_bank_mix
  import chr_comp_pkg::*;
#(
  parameter int OUTER_W = 8,
  parameter int LATCH_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         variant,
  input  ctrl_t              ctrl,
  input  logic [OUTER_W-1:0] outer,
  input  logic [LATCH_W-1:0] latch,
  output logic [OUTER_W-1:0] bank
);
  localparam logic [OUTER_W-1:0] FULL_MASK  = OUTER_W'((1 << LATCH_W) - 1);
  localparam logic [OUTER_W-1:0] SMALL_MASK = FULL_MASK >> 1;

  board_t             bv;
  logic               has_latch;
  logic [OUTER_W-1:0] mask;
  logic [OUTER_W-1:0] latch_ext;

  assign bv        = board_t'(variant);
  assign latch_ext = OUTER_W'(latch);

  always_comb begin
    has_latch = (bv == BV_SWAP) || (bv == BV_MERGE);
    if (!has_latch || ctrl.latch_off) mask = '0;
    else if (ctrl.small_win)          mask = SMALL_MASK;
    else                              mask = FULL_MASK;
  end

  always_comb begin
    if (bv == BV_MERGE) bank = outer | (latch_ext & mask);
    else                bank = (outer & ~mask) | (latch_ext & mask);
  end

  assert_no_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.latch_off || variant == 2'd0 || variant == 2'd3) |-> bank == outer);

  assert_swap_high_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (variant == 2'd1) |-> ((bank & ~FULL_MASK) == (outer & ~FULL_MASK)));

  assert_merge_keeps_outer_R6: assert property (@(posedge clk) disable iff (rst)
    (variant == 2'd2) |-> ((bank & outer) == outer));
endmodule

// File: rtl/chr_slot_pages.sv
module chr_slot_pages
  import chr_comp_pkg::*;
#(
  parameter int OUTER_W = 8,
  parameter int PAGE_W  = 10
) (
  input  logic [OUTER_W-1:0] bank,
  output logic [PAGE_W-1:0]  pages [SLOTS]
);
  localparam int FULL_W = OUTER_W + SLOT_SHIFT;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [FULL_W-1:0] full;
    assign full     = {bank, SLOT_SHIFT'(s)};
    assign pages[s] = PAGE_W'(full);   // modulo power-of-two ROM size
  end
endmodule

// File: rtl/chr8k_composer.sv
module chr8k_composer
  import chr_comp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OUTER_W    = 8,
  parameter int LATCH_W    = 2,
  parameter int CHR_ROM_KB = 1024,
  localparam int PAGE_W    = $clog2(CHR_ROM_KB),
  localparam int ADDR_W    = PAGE_W + SLOT_KB_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              board_variant,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [12:0]             ppu_addr,
  output logic                    chr8k_active,
  output logic [SLOTS*PAGE_W-1:0] slot_pages,
  output logic [ADDR_W-1:0]       chr_addr
);
  ctrl_t              ctrl_q;
  logic [OUTER_W-1:0] outer_q;
  logic [LATCH_W-1:0] latch_q;
  logic [OUTER_W-1:0] bank;
  logic [PAGE_W-1:0]  pages [SLOTS];

  chr_cfg_regs #(.DATA_W(DATA_W), .OUTER_W(OUTER_W), .LATCH_W(LATCH_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .outer_q(outer_q), .latch_q(latch_q)
  );

  chr_bank_mix #(.OUTER_W(OUTER_W), .LATCH_W(LATCH_W)) u_mix (
    .clk(clk), .rst(rst), .variant(board_variant), .ctrl(ctrl_q),
    .outer(outer_q), .latch(latch_q), .bank(bank)
  );

  chr_slot_pages #(.OUTER_W(OUTER_W), .PAGE_W(PAGE_W)) u_pages (
    .bank(bank), .pages(pages)
  );

  assign chr8k_active = ctrl_q.whole8k;

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    assign slot_pages[s*PAGE_W +: PAGE_W] = pages[s];
  end

  assign chr_addr = {pages[ppu_addr[12:10]], ppu_addr[9:0]};

  assert_offset_passes_R8: assert property (@(posedge clk) disable iff (rst)
    chr_addr[SLOT_KB_W-1:0] == ppu_addr[SLOT_KB_W-1:0]);

  assert_pages_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(board_variant) -> $stable(slot_pages)));
endmodule

// File: tb/test_chr8k_composer.sv
module test_chr8k_composer;
  localparam int PAGE_W = 10;
  localparam int NPAGES = 1024;
  localparam int NVEC   = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        board_variant = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [7:0]        wr_data = '0;
  logic [12:0]       ppu_addr = '0;
  logic              chr8k_active;
  logic [8*PAGE_W-1:0] slot_pages;
  logic [PAGE_W+9:0] chr_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  chr8k_composer i_chr8k_composer (
    .clk(clk), .rst(rst), .board_variant(board_variant), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ppu_addr(ppu_addr),
    .chr8k_active(chr8k_active), .slot_pages(slot_pages), .chr_addr(chr_addr)
  );

  // {variant, control, outer, latch, expected bank}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd0, 8'h40, 8'h05, 2'd3, 8'h05},  // R4 no latch on plain board
    {2'd1, 8'h40, 8'h05, 2'd2, 8'h06},  // R5 two-bit swap
    {2'd1, 8'h50, 8'h05, 2'd2, 8'h04},  // R5 one-bit swap clears bit 0
    {2'd1, 8'h50, 8'h06, 2'd3, 8'h07},  // R5
    {2'd1, 8'h60, 8'h05, 2'd2, 8'h05},  // R4 latch disabled by bit 5
    {2'd2, 8'h40, 8'h05, 2'd2, 8'h07},  // R6 merge
    {2'd2, 8'h50, 8'h04, 2'd3, 8'h05},  // R6 one-bit merge
    {2'd2, 8'h40, 8'h09, 2'd2, 8'h0B},  // R6
    {2'd3, 8'h40, 8'h09, 2'd2, 8'h09},  // R4 reserved variant
    {2'd1, 8'h40, 8'h7F, 2'd0, 8'h7C},  // R5 swap clears outer bits
    {2'd2, 8'h00, 8'h10, 2'd1, 8'h11},  // R3 inactive, R6
    {2'd1, 8'h40, 8'h83, 2'd1, 8'h81}   // R10 wrap with swap
  };

  function automatic logic [8*PAGE_W-1:0] exp_pages(input int bank);
    logic [8*PAGE_W-1:0] f;
    for (int i = 0; i < 8; i++) f[i*PAGE_W +: PAGE_W] = PAGE_W'((bank * 8 + i) % NPAGES);
    return f;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pages", 80'(slot_pages), 80'(exp_pages(0)));
    check("R1 active", 80'(chr8k_active), 80'd0);

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] v; logic [7:0] c, o, b; logic [1:0] l;
      int slot; int expa;
      {v, c, o, l, b} = VEC[k];
      board_variant = v;
      wr(2'd0, c);
      wr(2'd1, o);
      wr(2'd2, {6'b101010, l});
      slot = k % 8;
      ppu_addr = {3'(slot), 10'h2A5};
      #1;
      check("R7 pages", 80'(slot_pages), 80'(exp_pages(int'(b))));
      check("R3 active", 80'(chr8k_active), 80'(c[6]));
      expa = ((int'(b) * 8 + slot) % NPAGES) * 1024 + 'h2A5;
      check("R8 translate", 80'(chr_addr), 80'(expa));
    end

    // R2: write lands right after its edge
    board_variant = 2'd0;
    wr(2'd1, 8'h05);
    check("R2 immediate", 80'(slot_pages), 80'(exp_pages(5)));
    // R9: select 3 changes nothing
    wr(2'd3, 8'hFF);
    check("R9 sel3 pages", 80'(slot_pages), 80'(exp_pages(5)));
    check("R9 sel3 active", 80'(chr8k_active), 80'd1);
    // R2/R5: latch keeps only its low bits
    board_variant = 2'd1;
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFE);
    check("R2 latch width", 80'(slot_pages), 80'(exp_pages(2)));
    // R10: top ROM bank and next wraps
    board_variant = 2'd0;
    wr(2'd1, 8'h7F);
    check("R10 last bank", 80'(slot_pages), 80'(exp_pages(127)));
    wr(2'd1, 8'h80);
    check("R10 wrap", 80'(slot_pages), 80'(exp_pages(0)));
    // R1 soft reset from nonzero state
    wr(2'd1, 8'h33);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 soft reset pages", 80'(slot_pages), 80'(exp_pages(0)));
    check("R1 soft reset active", 80'(chr8k_active), 80'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule